// File: doc/BRIEF.md
# ADC Sample Sequencer Controller

This block schedules conversions for a 10-bit analog-to-digital converter. It has four independent sample sequences. Each sequence owns a list of up to eight steps, and each step selects one of three inputs: external channel 0, external channel 1 or the on-chip temperature sensor. Each sequence is armed by its own trigger line, which is chosen from a small set of shared event inputs. When more than one sequence is waiting, a 2-bit priority per sequence decides which one runs next.

The converter sits outside the block and is reached through a start/done handshake. The block pulses a start strobe together with a source code. The converter later returns a done strobe with the 10-bit result. Each result is written into a FIFO that belongs to the sequence that produced it. Software, or any consumer, drains that FIFO through a per-sequence read strobe. A step can be flagged to raise its sequence's interrupt. Another flag marks a step as the last one in its list. A per-sequence overflow flag records results that were dropped because the FIFO was full.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset there is no start strobe, every result FIFO reads empty, and all overflow and interrupt flags are 0.
- R2: A sequence becomes pending when it is enabled and the event line selected by its trigger-select field is high for a clock cycle. An event on any other line, or on any line while the sequence is disabled, starts no conversion.
- R3: A sequence runs its steps in order from step 0. Each step issues a one-cycle `conv_start` with `conv_src` set to that step's source code. The codes are 0 for channel 0, 1 for channel 1, and 2 for the temperature sensor; code 3 is issued as 2.
- R4: A sequence ends after the step whose last-step flag is set. If no step in its list has that flag, it ends after step 7, so at most eight conversions run per trigger.
- R5: Every 10-bit result goes into its own sequence's FIFO, in conversion order. Pulsing `rd_en[s]` while the FIFO is not empty presents the oldest entry on `rd_data` slice s in the following cycle.
- R6: When several sequences are pending and no sequence is running, the one with the numerically lowest priority value runs first. Ties go to the lower sequence number.
- R7: A running sequence completes all of its steps before any other sequence starts, whatever the priorities.
- R8: A trigger for a sequence that is already pending or running is absorbed: it adds no further run of that sequence.
- R9: A result arriving while its FIFO holds 8 entries is discarded, and the FIFO contents are kept. The sequence's overflow flag is then set and stays set until `ovf_clr` is pulsed.
- R10: When a step whose interrupt flag is set finishes converting, `irq[s]` goes to 1 and stays there until `irq_clr[s]` is pulsed. Steps without the flag leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_evt | input | 4 | Shared trigger event lines |
| cfg_en | input | 4 | Per-sequence enable |
| cfg_trig_sel | input | 8 | Per-sequence event line select, 2 bits each |
| cfg_prio | input | 8 | Per-sequence priority, 2 bits each, 0 highest |
| cfg_src | input | 64 | Source code per step, 2 bits each, index seq*8+step |
| cfg_last | input | 32 | Last-step flag per step |
| cfg_ie | input | 32 | Interrupt flag per step |
| conv_start | output | 1 | One-cycle converter start strobe |
| conv_src | output | 2 | Source for the conversion being started |
| conv_done | input | 1 | Converter result valid strobe |
| conv_data | input | 10 | Converter result |
| rd_en | input | 4 | Per-sequence FIFO read strobe |
| rd_data | output | 40 | Per-sequence read data, 10 bits each |
| rd_empty | output | 4 | Per-sequence FIFO empty |
| ovf | output | 4 | Sticky per-sequence overflow flag |
| ovf_clr | input | 4 | Clears the overflow flag |
| irq | output | 4 | Sticky per-sequence interrupt |
| irq_clr | input | 4 | Clears the interrupt |

## Verification
The assertions assume that the converter raises `conv_done` for exactly one cycle per start, never in the same cycle as `conv_start`, and only while a conversion is outstanding. The bench's converter model answers each start with a single done two cycles later, and it stamps each result with its source and a running count. This lets the bench recompute order and source arithmetically. Retriggers and reads are placed at points where no sequence is finishing in that cycle. The bench therefore never relies on how a trigger and a completion landing in the same cycle are resolved.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } seq_state_e;

  localparam logic [1:0] SRC_CH0  = 2'd0;
  localparam logic [1:0] SRC_CH1  = 2'd1;
  localparam logic [1:0] SRC_TEMP = 2'd2;

  function automatic logic [1:0] map_src(input logic [1:0] code);
    return (code == 2'd3) ? SRC_TEMP : code;
  endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int NUM_SEQ  = 4,
  parameter int NUM_TRIG = 4,
  localparam int TSEL_W  = $clog2(NUM_TRIG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_TRIG-1:0]       trig_evt,
  input  logic [NUM_SEQ-1:0]        cfg_en,
  input  logic [NUM_SEQ*TSEL_W-1:0] cfg_trig_sel,
  input  logic [NUM_SEQ-1:0]        seq_clr,
  output logic [NUM_SEQ-1:0]        pend
);

  logic [NUM_SEQ-1:0] hit;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    assign hit[s] = cfg_en[s] && trig_evt[cfg_trig_sel[s*TSEL_W +: TSEL_W]];

    always_ff @(posedge clk) begin
      if (rst) pend[s] <= 1'b0;
      else     pend[s] <= (pend[s] && !seq_clr[s]) || hit[s];
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend[s] && !seq_clr[s]) |=> pend[s]);
  end

endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
  parameter int NUM_SEQ = 4,
  parameter int PRIO_W  = 2,
  localparam int SEQ_W  = $clog2(NUM_SEQ)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SEQ-1:0]        pend,
  input  logic [NUM_SEQ*PRIO_W-1:0] prio,
  output logic                      gnt_vld,
  output logic [SEQ_W-1:0]          gnt_idx
);

  logic [PRIO_W-1:0] best;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    best    = '1;
    for (int i = 0; i < NUM_SEQ; i++) begin
      if (pend[i] && (!gnt_vld || prio[i*PRIO_W +: PRIO_W] < best)) begin
        gnt_vld = 1'b1;
        gnt_idx = SEQ_W'(i);
        best    = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  logic [NUM_SEQ-1:0] rival;
  logic [PRIO_W-1:0]  gp;
  assign gp = prio[gnt_idx*PRIO_W +: PRIO_W];

  always_comb begin
    for (int j = 0; j < NUM_SEQ; j++) begin
      rival[j] = pend[j] &&
                 ((prio[j*PRIO_W +: PRIO_W] < gp) ||
                  ((prio[j*PRIO_W +: PRIO_W] == gp) && (SEQ_W'(j) < gnt_idx)));
    end
  end

  // R6
  no_better_rival_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> (rival == '0));

  // R6
  grant_when_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> (gnt_vld && pend[gnt_idx]));

endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         ovf,
  input  logic         ovf_clr
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             full, do_wr, do_rd;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + PTR_W'(1);
      if (do_rd) rp <= rp + PTR_W'(1);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
      if (wr && full)   ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R9
  overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && full) |=> (ovf && cnt == CNT_W'(DEPTH) - CNT_W'($past(do_rd))));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && empty && !wr) |=> empty);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NUM_SEQ    = 4,
  parameter int MAX_STEPS  = 8,
  parameter int RES_W      = 10,
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_TRIG   = 4,
  parameter int PRIO_W     = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_TRIG-1:0]                  trig_evt,
  input  logic [NUM_SEQ-1:0]                   cfg_en,
  input  logic [NUM_SEQ*$clog2(NUM_TRIG)-1:0]  cfg_trig_sel,
  input  logic [NUM_SEQ*PRIO_W-1:0]            cfg_prio,
  input  logic [NUM_SEQ*MAX_STEPS*2-1:0]       cfg_src,
  input  logic [NUM_SEQ*MAX_STEPS-1:0]         cfg_last,
  input  logic [NUM_SEQ*MAX_STEPS-1:0]         cfg_ie,
  output logic                                 conv_start,
  output logic [1:0]                           conv_src,
  input  logic                                 conv_done,
  input  logic [RES_W-1:0]                     conv_data,
  input  logic [NUM_SEQ-1:0]                   rd_en,
  output logic [NUM_SEQ*RES_W-1:0]             rd_data,
  output logic [NUM_SEQ-1:0]                   rd_empty,
  output logic [NUM_SEQ-1:0]                   ovf,
  input  logic [NUM_SEQ-1:0]                   ovf_clr,
  output logic [NUM_SEQ-1:0]                   irq,
  input  logic [NUM_SEQ-1:0]                   irq_clr
);

  import adc_seq_pkg::*;

  localparam int SEQ_W  = $clog2(NUM_SEQ);
  localparam int STEP_W = $clog2(MAX_STEPS);
  localparam int ENT_W  = SEQ_W + STEP_W;

  seq_state_e         state_q;
  logic [SEQ_W-1:0]   cur_q;
  logic [STEP_W-1:0]  step_q;
  logic [NUM_SEQ-1:0] pend, seq_clr, wr_vec;
  logic               gnt_vld;
  logic [SEQ_W-1:0]   gnt_idx;

  logic [STEP_W-1:0]  step_nxt;
  logic [ENT_W-1:0]   cur_ent, nxt_ent, first_ent;
  logic               is_last, ie_now, run_done;

  assign step_nxt  = step_q + STEP_W'(1);
  assign cur_ent   = {cur_q, step_q};
  assign nxt_ent   = {cur_q, step_nxt};
  assign first_ent = {gnt_idx, {STEP_W{1'b0}}};
  assign is_last   = cfg_last[cur_ent] || (step_q == STEP_W'(MAX_STEPS - 1));
  assign ie_now    = cfg_ie[cur_ent];
  assign run_done  = (state_q == ST_RUN) && conv_done;

  adc_seq_trig #(.NUM_SEQ(NUM_SEQ), .NUM_TRIG(NUM_TRIG)) u_trig (
    .clk(clk), .rst(rst), .trig_evt(trig_evt), .cfg_en(cfg_en),
    .cfg_trig_sel(cfg_trig_sel), .seq_clr(seq_clr), .pend(pend)
  );

  adc_seq_arb #(.NUM_SEQ(NUM_SEQ), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .prio(cfg_prio),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      step_q     <= '0;
      conv_start <= 1'b0;
      conv_src   <= SRC_CH0;
    end else begin
      conv_start <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (gnt_vld) begin
            cur_q      <= gnt_idx;
            step_q     <= '0;
            conv_start <= 1'b1;
            conv_src   <= map_src(cfg_src[{first_ent, 1'b0} +: 2]);
            state_q    <= ST_RUN;
          end
        end
        default: begin
          if (conv_done) begin
            if (is_last) begin
              state_q <= ST_IDLE;
            end else begin
              step_q     <= step_nxt;
              conv_start <= 1'b1;
              conv_src   <= map_src(cfg_src[{nxt_ent, 1'b0} +: 2]);
            end
          end
        end
      endcase
    end
  end

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    assign wr_vec[s]  = run_done && (cur_q == SEQ_W'(s));
    assign seq_clr[s] = wr_vec[s] && is_last;

    adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(RES_W)) u_fifo (
      .clk(clk), .rst(rst), .wr(wr_vec[s]), .wdata(conv_data),
      .rd(rd_en[s]), .rdata(rd_data[s*RES_W +: RES_W]),
      .empty(rd_empty[s]), .ovf(ovf[s]), .ovf_clr(ovf_clr[s])
    );

    always_ff @(posedge clk) begin
      if (rst)                        irq[s] <= 1'b0;
      else if (wr_vec[s] && ie_now)   irq[s] <= 1'b1;
      else if (irq_clr[s])            irq[s] <= 1'b0;
    end

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[s]) |-> $past(wr_vec[s]));
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  // R7
  run_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !(conv_done && is_last)) |=> (state_q == ST_RUN && $stable(cur_q)));

  // R2
  start_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && gnt_vld) |-> pend[gnt_idx]);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam int NS = 4;
  localparam int MS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  trig_evt = '0;
  logic [3:0]  cfg_en = '0;
  logic [7:0]  cfg_trig_sel = '0;
  logic [7:0]  cfg_prio = '0;
  logic [63:0] cfg_src = '0;
  logic [31:0] cfg_last = '0;
  logic [31:0] cfg_ie = '0;
  logic        conv_start;
  logic [1:0]  conv_src;
  logic        conv_done;
  logic [9:0]  conv_data;
  logic [3:0]  rd_en = '0;
  logic [39:0] rd_data;
  logic [3:0]  rd_empty, ovf, irq;
  logic [3:0]  ovf_clr = '0;
  logic [3:0]  irq_clr = '0;

  int n_chk = 0;
  int n_bad = 0;
  int conv_cnt = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .trig_evt(trig_evt), .cfg_en(cfg_en),
    .cfg_trig_sel(cfg_trig_sel), .cfg_prio(cfg_prio), .cfg_src(cfg_src),
    .cfg_last(cfg_last), .cfg_ie(cfg_ie), .conv_start(conv_start),
    .conv_src(conv_src), .conv_done(conv_done), .conv_data(conv_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .ovf(ovf),
    .ovf_clr(ovf_clr), .irq(irq), .irq_clr(irq_clr)
  );

  // converter model: done two negedges after a start is seen
  initial begin
    int busy;
    logic [1:0] lat_src;
    busy = 0;
    lat_src = '0;
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (busy > 0) begin
        busy--;
        if (busy == 0) begin
          conv_data = {lat_src, 8'(conv_cnt % 256)};
          conv_done = 1'b1;
          conv_cnt++;
        end
      end
      if (conv_start && busy == 0) begin
        lat_src = conv_src;
        busy = 2;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig(logic [3:0] m);
    trig_evt = m;
    tick(1);
    trig_evt = '0;
  endtask

  task automatic read_one(int s, output int v);
    rd_en[s] = 1'b1;
    tick(1);
    rd_en[s] = 1'b0;
    v = int'(rd_data[s*10 +: 10]);
  endtask

  task automatic drain_all();
    int v;
    for (int s = 0; s < NS; s++) begin
      while (!rd_empty[s]) read_one(s, v);
    end
    ovf_clr = '1;
    irq_clr = '1;
    tick(1);
    ovf_clr = '0;
    irq_clr = '0;
  endtask

  function automatic int src_of(int b, int k);
    return (b + k) % 3;
  endfunction

  // steps 0..len-1 active; the last one flagged unless len == MS
  task automatic set_seq(int s, int len, int b, bit ie);
    for (int k = 0; k < MS; k++) begin
      cfg_src[(s*MS+k)*2 +: 2] = 2'(src_of(b, k));
      cfg_last[s*MS+k] = (len < MS) && (k == len - 1);
      cfg_ie[s*MS+k]   = ie && (k == len - 1);
    end
  endtask

  initial begin
    int v, base, rank;
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 conv_start", int'(conv_start), 0);
    check("R1 rd_empty", int'(rd_empty), 15);
    check("R1 ovf", int'(ovf), 0);
    check("R1 irq", int'(irq), 0);

    for (int s = 0; s < NS; s++) cfg_trig_sel[s*2 +: 2] = 2'(s);

    // R3 R4 R5 R10 sweep over sequence, length and source pattern
    for (int s = 0; s < NS; s++) begin
      for (int len = 1; len <= MS; len++) begin
        for (int b = 0; b < 3; b++) begin
          cfg_en = 4'(1 << s);
          set_seq(s, len, b, b != 1);
          base = conv_cnt;
          pulse_trig(4'(1 << s));
          tick(len * 4 + 8);
          check("R4 conversion count", conv_cnt - base, len);
          for (int k = 0; k < len; k++) begin
            read_one(s, v);
            check("R3 R5 result", v, src_of(b, k) * 256 + (base + k) % 256);
          end
          check("R5 empty after drain", int'(rd_empty[s]), 1);
          check("R10 irq", int'(irq), (b != 1) ? (1 << s) : 0);
          drain_all();
          check("R10 irq cleared", int'(irq), 0);
        end
      end
    end

    // R6 all 256 priority settings, four one-step sequences at once
    cfg_en = 4'hF;
    for (int s = 0; s < NS; s++) set_seq(s, 1, 0, 1'b1);
    for (int p = 0; p < 256; p++) begin
      cfg_prio = 8'(p);
      base = conv_cnt;
      pulse_trig(4'hF);
      tick(30);
      check("R10 irq all", int'(irq), 15);
      for (int i = 0; i < NS; i++) begin
        rank = 0;
        for (int j = 0; j < NS; j++) begin
          if ((((p >> (2*j)) & 3) < ((p >> (2*i)) & 3)) ||
              ((((p >> (2*j)) & 3) == ((p >> (2*i)) & 3)) && j < i)) rank++;
        end
        read_one(i, v);
        check("R6 order", v, (base + rank) % 256);
      end
      drain_all();
    end

    // R7 low-priority run is not preempted
    cfg_prio = {2'd3, 2'd2, 2'd1, 2'd0};
    cfg_en = 4'b1001;
    set_seq(3, 8, 1, 1'b0);
    set_seq(0, 1, 2, 1'b0);
    base = conv_cnt;
    pulse_trig(4'b1000);
    tick(4);
    pulse_trig(4'b0001);
    tick(60);
    for (int k = 0; k < 8; k++) begin
      read_one(3, v);
      check("R7 long run contiguous", v, src_of(1, k) * 256 + (base + k) % 256);
    end
    read_one(0, v);
    check("R7 waiting run after", v, 2 * 256 + (base + 8) % 256);
    drain_all();

    // R8 retriggers while pending and while running
    cfg_en = 4'b0010;
    set_seq(1, 3, 0, 1'b0);
    base = conv_cnt;
    trig_evt = 4'b0010;
    tick(1);
    trig_evt = 4'b0010;
    tick(1);
    trig_evt = '0;
    tick(3);
    pulse_trig(4'b0010);
    tick(30);
    check("R8 single run", conv_cnt - base, 3);
    for (int k = 0; k < 3; k++) read_one(1, v);
    check("R8 fifo empty", int'(rd_empty[1]), 1);
    drain_all();

    // R2 disabled sequence and wrong event line
    cfg_en = 4'b0000;
    set_seq(2, 2, 0, 1'b1);
    base = conv_cnt;
    pulse_trig(4'b0100);
    tick(20);
    check("R2 disabled no conv", conv_cnt - base, 0);
    check("R2 disabled empty", int'(rd_empty[2]), 1);
    cfg_en = 4'b0100;
    cfg_trig_sel[4 +: 2] = 2'd3;
    pulse_trig(4'b0100);
    tick(20);
    check("R2 wrong line no conv", conv_cnt - base, 0);
    check("R2 wrong line irq", int'(irq), 0);
    pulse_trig(4'b1000);
    tick(20);
    check("R2 selected line", conv_cnt - base, 2);
    drain_all();
    cfg_trig_sel[4 +: 2] = 2'd2;

    // R9 overflow
    cfg_en = 4'b0001;
    set_seq(0, 8, 2, 1'b0);
    base = conv_cnt;
    pulse_trig(4'b0001);
    tick(50);
    check("R9 no ovf at full", int'(ovf[0]), 0);
    pulse_trig(4'b0001);
    tick(50);
    check("R9 conversions", conv_cnt - base, 16);
    check("R9 ovf set", int'(ovf[0]), 1);
    for (int k = 0; k < 8; k++) begin
      read_one(0, v);
      check("R9 kept data", v, src_of(2, k) * 256 + (base + k) % 256);
    end
    check("R9 empty", int'(rd_empty[0]), 1);
    check("R9 ovf sticky", int'(ovf[0]), 1);
    ovf_clr = 4'b0001;
    tick(1);
    ovf_clr = '0;
    tick(1);
    check("R9 ovf cleared", int'(ovf[0]), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule